// File: doc/BRIEF.md
# Shared ATA Bus Clock Source Switcher

Two ATA channels share one bus clock. That clock comes either from a PLL or straight from the host bus clock. Before each command is issued, this block works out which source the command needs. A write needs the PLL. A command on a host bus strapped for 66 MHz operation also needs the PLL. Every other command needs the host bus clock. If the needed source is already selected, the command is accepted at once.

If the needed source differs from the current one and no other channel is active, the block runs an ordered switch sequence. The steps are: isolate every channel from the bus, change the source select, hold channel reset, reset each channel's protocol state machine, release channel reset, and reconnect. Each step lasts a programmable number of cycles. Accept is raised only when the sequence has finished.

If a switch is needed while another channel still has a command in flight, the request is deferred and nothing else changes. The issuing layer then retries the request later.

Top module: `clk_src_switch`

## Requirements
- R1: While and after reset, the select output carries the PLL code 0x21, and tristate, channel reset, state-machine reset, accept and defer are all low.
- R2: A request needs the PLL source when write_i or fast_bus_i is high. When both are low, it needs the host bus source.
- R3: A request whose needed source equals the current source raises accept_o for one cycle, in the cycle after the request edge. No switch step starts, whatever the busy flags are.
- R4: A request that needs a source change while any channel other than chan_i has its busy bit set raises defer_o for one cycle, in the cycle after the request edge. The select output and tristate stay unchanged. The requesting channel's own busy bit plays no part in this decision.
- R5: A needed change with no other channel busy runs six steps in this order. Step 0: all tristate bits high. Step 1: the select output takes the new code. Step 2: chan_rst_o high. Step 3: chan_rst_o and every sm_rst_o bit high. Step 4: chan_rst_o low while tristate stays high. Step 5: tristate low.
- R6: Each step lasts N cycles. N is step_cycles_i sampled at the request, with 0 treated as 1. accept_o is high for one cycle, 6*N cycles after the request edge.
- R7: The select code is 0x21 for the PLL source and 0x23 for the host bus source.
- R8: The current source becomes the new one only when the sequence completes. Later requests are judged against that updated source.
- R9: Requests that arrive while a sequence runs are ignored. They produce no accept or defer, and they do not change the sequence.
- R10: chan_rst_o is asserted only while every channel is tristated. sm_rst_o is asserted only while chan_rst_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Issue request, one cycle |
| chan_i | input | CH_W | Channel issuing the command |
| write_i | input | 1 | Command writes to the device |
| fast_bus_i | input | 1 | Host bus strapped for 66 MHz |
| chan_busy_i | input | NUM_CH | Per-channel command-active flags |
| step_cycles_i | input | STEP_W | Minimum cycles per switch step (0 acts as 1) |
| sel_code_o | output | 8 | Clock source select code |
| tristate_o | output | NUM_CH | Per-channel bus isolation |
| chan_rst_o | output | 1 | Channel reset during switch |
| sm_rst_o | output | NUM_CH | Per-channel state-machine reset |
| accept_o | output | 1 | Command may be issued |
| defer_o | output | 1 | Command must be retried later |

## Verification
Every output is a register or a decode of the state register, so results change only at clock edges. Accept or defer for a request is due in the cycle right after the request edge. During a switch, the bench computes the step index from the cycle count after the request edge (index = cycles / N). It checks each output in every one of the 6*N cycles, and then checks accept in the cycle after that. All samples are taken at the falling edge, between the edge that produced a value and the next one. The bench also injects stray requests during a sequence; these are expected to leave every one of those cycle-by-cycle checks unchanged.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISO,
    ST_SEL,
    ST_CRST,
    ST_SMRST,
    ST_REL,
    ST_RECON
  } seq_st_e;

  localparam logic [7:0] CODE_PLL  = 8'h21;
  localparam logic [7:0] CODE_HOST = 8'h23;

  function automatic logic [7:0] src_code(input logic pll);
    return pll ? CODE_PLL : CODE_HOST;
  endfunction

endpackage

// File: rtl/clk_src_decide.sv
module clk_src_decide #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic              write_i,
  input  logic              fast_bus_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [NUM_CH-1:0] chan_busy_i,
  output logic              need_pll_o,
  output logic              other_busy_o
);

  logic [NUM_CH-1:0] other_mask;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_other
    assign other_mask[g] = chan_busy_i[g] && (chan_i != CH_W'(g));
  end

  assign need_pll_o   = write_i | fast_bus_i;
  assign other_busy_o = |other_mask;

endmodule

// File: rtl/clk_src_step_timer.sv
module clk_src_step_timer #(
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [STEP_W-1:0] len_i,
  input  logic              run_i,
  output logic              step_end_o
);

  logic [STEP_W-1:0] len_q;
  logic [STEP_W-1:0] cnt_q;

  assign step_end_o = run_i && (cnt_q == len_q - STEP_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= STEP_W'(1);
      cnt_q <= '0;
    end else if (load_i) begin
      len_q <= (len_i == '0) ? STEP_W'(1) : len_i;
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= step_end_o ? '0 : cnt_q + STEP_W'(1);
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < len_q)); // R6

  AST_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q != '0); // R6

endmodule

// File: rtl/clk_src_seq.sv
module clk_src_seq
  import clk_src_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              target_pll_i,
  input  logic              step_end_i,
  output logic              run_o,
  output logic              done_o,
  output logic              cur_pll_o,
  output logic              sel_pll_o,
  output logic [NUM_CH-1:0] tristate_o,
  output logic              chan_rst_o,
  output logic [NUM_CH-1:0] sm_rst_o
);

  seq_st_e st_q, st_d;
  logic    tgt_q, cur_q, sel_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i)    st_d = ST_ISO;
      ST_ISO:   if (step_end_i) st_d = ST_SEL;
      ST_SEL:   if (step_end_i) st_d = ST_CRST;
      ST_CRST:  if (step_end_i) st_d = ST_SMRST;
      ST_SMRST: if (step_end_i) st_d = ST_REL;
      ST_REL:   if (step_end_i) st_d = ST_RECON;
      ST_RECON: if (step_end_i) st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      tgt_q <= 1'b1;
      cur_q <= 1'b1;
      sel_q <= 1'b1;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start_i) tgt_q <= target_pll_i;
      if (st_q == ST_ISO && step_end_i) sel_q <= tgt_q;
      if (done_o) cur_q <= tgt_q;
    end
  end

  assign run_o      = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_RECON) && step_end_i;
  assign cur_pll_o  = cur_q;
  assign sel_pll_o  = sel_q;
  assign chan_rst_o = (st_q == ST_CRST) || (st_q == ST_SMRST);
  assign tristate_o = {NUM_CH{(st_q != ST_IDLE) && (st_q != ST_RECON)}};
  assign sm_rst_o   = {NUM_CH{st_q == ST_SMRST}};

  AST_SEL_WHILE_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_q) |-> (&tristate_o)); // R5

  AST_CRST_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_o |-> (&tristate_o)); // R10

  AST_SMRST_IN_CRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sm_rst_o) |-> chan_rst_o); // R10

  AST_CUR_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_q) |-> $past(done_o)); // R8

  AST_IDLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> (sel_q == cur_q)); // R8

endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import clk_src_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int STEP_W = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              write_i,
  input  logic              fast_bus_i,
  input  logic [NUM_CH-1:0] chan_busy_i,
  input  logic [STEP_W-1:0] step_cycles_i,
  output logic [7:0]        sel_code_o,
  output logic [NUM_CH-1:0] tristate_o,
  output logic              chan_rst_o,
  output logic [NUM_CH-1:0] sm_rst_o,
  output logic              accept_o,
  output logic              defer_o
);

  logic need_pll, other_busy;
  logic run, done, cur_pll, sel_pll, step_end;
  logic start, mismatch, go_issue, go_defer, go_switch;
  logic accept_q, defer_q;

  clk_src_decide #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_decide (
    .write_i      (write_i),
    .fast_bus_i   (fast_bus_i),
    .chan_i       (chan_i),
    .chan_busy_i  (chan_busy_i),
    .need_pll_o   (need_pll),
    .other_busy_o (other_busy)
  );

  assign start     = req_i && !run;
  assign mismatch  = (need_pll != cur_pll);
  assign go_issue  = start && !mismatch;
  assign go_defer  = start && mismatch && other_busy;
  assign go_switch = start && mismatch && !other_busy;

  clk_src_step_timer #(.STEP_W(STEP_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (go_switch),
    .len_i      (step_cycles_i),
    .run_i      (run),
    .step_end_o (step_end)
  );

  clk_src_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (go_switch),
    .target_pll_i (need_pll),
    .step_end_i   (step_end),
    .run_o        (run),
    .done_o       (done),
    .cur_pll_o    (cur_pll),
    .sel_pll_o    (sel_pll),
    .tristate_o   (tristate_o),
    .chan_rst_o   (chan_rst_o),
    .sm_rst_o     (sm_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q <= 1'b0;
      defer_q  <= 1'b0;
    end else begin
      accept_q <= go_issue || done;
      defer_q  <= go_defer;
    end
  end

  assign accept_o   = accept_q;
  assign defer_o    = defer_q;
  assign sel_code_o = src_code(sel_pll);

  AST_ACC_DEF_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && defer_o)); // R3

  AST_ACCEPT_CONNECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (tristate_o == '0) && !chan_rst_o); // R5

  AST_DEFER_HOLDS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    defer_o |-> $stable(sel_code_o) && (tristate_o == '0)); // R4

  AST_SEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_code_o == CODE_PLL) || (sel_code_o == CODE_HOST)); // R7

  AST_NO_RESP_IN_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run)) |-> !defer_o); // R9

endmodule

// File: tb/clk_src_switch_bench.sv
module clk_src_switch_bench;

  localparam int NUM_CH = 2;
  localparam int CH_W   = 1;
  localparam int STEP_W = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic [CH_W-1:0]   chan_i = '0;
  logic              write_i = 1'b0;
  logic              fast_bus_i = 1'b0;
  logic [NUM_CH-1:0] chan_busy_i = '0;
  logic [STEP_W-1:0] step_cycles_i = '0;
  logic [7:0]        sel_code_o;
  logic [NUM_CH-1:0] tristate_o;
  logic              chan_rst_o;
  logic [NUM_CH-1:0] sm_rst_o;
  logic              accept_o;
  logic              defer_o;

  int  errs = 0;
  int  checks = 0;
  int  cycles = 0;
  bit  cur_pll = 1'b1;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  clk_src_switch #(.NUM_CH(NUM_CH), .STEP_W(STEP_W)) u_clk_src_switch (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .chan_i(chan_i),
    .write_i(write_i), .fast_bus_i(fast_bus_i), .chan_busy_i(chan_busy_i),
    .step_cycles_i(step_cycles_i), .sel_code_o(sel_code_o),
    .tristate_o(tristate_o), .chan_rst_o(chan_rst_o), .sm_rst_o(sm_rst_o),
    .accept_o(accept_o), .defer_o(defer_o)
  );

  function automatic logic [7:0] exp_code(input bit pll);
    return pll ? 8'h21 : 8'h23;
  endfunction

  function automatic bit exp_need(input bit w, input bit f);
    return w | f;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic do_req(input bit w, input bit f, input logic [CH_W-1:0] ch,
                        input logic [NUM_CH-1:0] bz, input int n, input bit stray);
    bit need;
    bit oth;
    int neff;
    need = exp_need(w, f);
    oth  = |(bz & ~(NUM_CH'(1) << ch));
    neff = (n == 0) ? 1 : n;
    @(negedge clk);
    write_i = w; fast_bus_i = f; chan_i = ch; chan_busy_i = bz;
    step_cycles_i = STEP_W'(n); req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    if (need == cur_pll) begin
      chk("R3/R8 accept", accept_o, 1);
      chk("R3 defer", defer_o, 0);
      chk("R3 no isolate", tristate_o, 0);
    end else if (oth) begin
      chk("R4 defer", defer_o, 1);
      chk("R4 accept", accept_o, 0);
      chk("R4 tristate", tristate_o, 0);
      chk("R4/R7 select held", sel_code_o, exp_code(cur_pll));
    end else begin
      for (int j = 0; j < 6 * neff; j++) begin
        int s;
        if (j > 0) @(negedge clk);
        s = j / neff;
        req_i = 1'b0;
        chk("R5 tristate", tristate_o, (s <= 4) ? 2'b11 : 2'b00);
        chk("R5/R7 select", sel_code_o, exp_code((s >= 1) ? need : cur_pll));
        chk("R5/R10 chan reset", chan_rst_o, (s == 2 || s == 3) ? 1 : 0);
        chk("R5/R10 sm reset", sm_rst_o, (s == 3) ? 2'b11 : 2'b00);
        chk("R6/R9 no early accept", accept_o, 0);
        chk("R9 no defer", defer_o, 0);
        if (stray && j < 6 * neff - 1 && ($urandom % 3 == 0)) begin
          write_i = 1'($urandom); fast_bus_i = 1'($urandom);
          chan_i = CH_W'($urandom); chan_busy_i = NUM_CH'($urandom);
          req_i = 1'b1;
        end
      end
      @(negedge clk);
      req_i = 1'b0;
      step_cycles_i = STEP_W'(n);
      chk("R6 accept after 6N", accept_o, 1);
      chk("R6 reconnected", tristate_o, 0);
      chk("R8 new select", sel_code_o, exp_code(need));
      cur_pll = need;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 reset select", sel_code_o, 8'h21);
    chk("R1 reset tristate", tristate_o, 0);
    chk("R1 reset chan reset", chan_rst_o, 0);
    chk("R1 reset sm reset", sm_rst_o, 0);
    chk("R1 reset accept", accept_o, 0);
    chk("R1 reset defer", defer_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after reset select", sel_code_o, 8'h21);

    // R2: plain read needs host clock; N=0 acts as 1 (R6)
    do_req(1'b0, 1'b0, 1'b0, 2'b00, 0, 1'b0);
    // R4: write needs PLL, other channel busy
    do_req(1'b1, 1'b0, 1'b0, 2'b10, 2, 1'b0);
    // R4: only own channel busy, switch proceeds
    do_req(1'b1, 1'b0, 1'b0, 2'b01, 3, 1'b0);
    // R2/R3: fast bus read needs PLL, already selected, busy ignored
    do_req(1'b0, 1'b1, 1'b1, 2'b11, 1, 1'b0);
    // R9: stray requests during a switch back to host
    do_req(1'b0, 1'b0, 1'b1, 2'b00, 2, 1'b1);
    // R8: next read judged against host source
    do_req(1'b0, 1'b0, 1'b0, 2'b11, 1, 1'b0);
    // R6: longest step
    do_req(1'b1, 1'b1, 1'b1, 2'b00, 15, 1'b1);

    for (int i = 0; i < 200; i++) begin
      do_req(1'($urandom), 1'($urandom % 4 == 0), CH_W'($urandom),
             NUM_CH'($urandom), int'($urandom % 5), 1'($urandom));
    end
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule